// File: doc/BRIEF.md
# Successive-Approximation ADC Conversion Sequencer

This block runs an 8-bit successive-approximation conversion for a microcontroller analog front end. Software writes a start bit. The sequencer waits for the instruction-cycle phase strobe and then stops sampling. It times the conversion with a conversion clock. That clock comes either from a divided core oscillator or from a free-running RC oscillator, whose edges arrive as strobes already synchronized to the core clock. The sequencer drives a trial code to the external DAC and resolves one bit per conversion clock from the comparator. The most significant bit is decided first.

A conversion always spans eleven conversion clocks. The first clock sets up the trial register. The next eight decide the bits. One is spare, and the last one commits the code. At the commit step the result register updates, the start bit drops and the completion flag rises, all on the same edge. Until that edge the previous result stays visible. After a conversion the sampler gets two conversion clocks to recover before a pending start may take effect. Clearing the start bit in mid-conversion cancels the conversion without touching the result or the flag.

Top module: `adc_sar_seq`

## Requirements
- R1: A conversion starts on the first clock edge at which `q4_i` is high and the start bit is set. From that edge `sample_o` is 0 until the conversion ends or is cancelled.
- R2: `clk_sel_i` values 0, 1 and 2 select a conversion clock of core clock /2, /8 and /32. Completion happens exactly 11 conversion periods (22, 88 or 352 core clocks) after the start edge.
- R3: `clk_sel_i` = 3 selects the RC conversion clock. The block waits one instruction cycle, up to the next `q4_i` strobe. It then counts `rc_tick_i` pulses and completes on the edge of the 11th pulse.
- R4: Bits are tried from bit 7 down to bit 0. Each trial sets the bit under test in `trial_o`. `cmp_i` = 1 keeps the bit and `cmp_i` = 0 clears it. With `cmp_i = (vin >= trial_o)`, the final code equals vin.
- R5: `result_o` holds its previous value during the whole conversion and changes only on the completion edge.
- R6: On the completion edge `go_o` goes to 0 and `irq_o` goes to 1. `irq_o` stays 1 until `irq_clr_i` is asserted. `irq_clr_i` clears it on the next edge.
- R7: After completion a recovery period of 2 conversion clocks follows. A start bit written during recovery takes effect only on the first `q4_i` edge after recovery ends.
- R8: `go_clr_i` during a conversion clears `go_o` and returns the block to sampling on the next edge. `result_o` is left unchanged and `irq_o` is not set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Core oscillator clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| q4_i | input | 1 | Instruction-cycle phase strobe, one core clock per cycle |
| go_set_i | input | 1 | Software write that sets the start bit |
| go_clr_i | input | 1 | Software write that clears the start bit (cancels a conversion) |
| irq_clr_i | input | 1 | Software clear of the completion flag |
| clk_sel_i | input | 2 | Conversion clock source: 0 /2, 1 /8, 2 /32, 3 RC |
| rc_tick_i | input | 1 | Synchronized RC oscillator edge strobe |
| cmp_i | input | 1 | Comparator: 1 when the input is at or above the trial code |
| trial_o | output | RES_W (8) | Trial code to the DAC |
| sample_o | output | 1 | Sample-and-hold tracking enable |
| go_o | output | 1 | Start bit (busy) readback |
| irq_o | output | 1 | Completion interrupt flag |
| result_o | output | RES_W (8) | Conversion result register |

## Verification
If the tick counter or the divider is off, the error shows at the ports as a completion edge moved by whole conversion periods. The bench measures the start-to-flag delay exactly in every clock mode, so even a one-clock error is visible. A bad trial mask or comparator decision shows as a wrong final code after the conversion. Input codes with alternating, all-ones, all-zeros and single-bit patterns expose any stuck or swapped bit position. Premature result updates, a missed recovery hold-off and a cancel that leaks into the result all appear within one conversion. The bench monitors `result_o`, `go_o`, `sample_o` and `irq_o` on every cycle of it.

// File: rtl/adc_seq_pkg.sv
package adc_seq_pkg;

  typedef enum logic [1:0] {
    ST_IDLE   = 2'd0,
    ST_RCWAIT = 2'd1,
    ST_CONV   = 2'd2,
    ST_RECOV  = 2'd3
  } seq_state_e;

  localparam logic [1:0] SEL_RC = 2'd3;

endpackage

// File: rtl/adc_seq_clkgen.sv
module adc_seq_clkgen
  import adc_seq_pkg::*;
#(
  parameter int DIV0 = 2,
  parameter int DIV1 = 8,
  parameter int DIV2 = 32,
  localparam int DMAX = (DIV2 > DIV1) ? ((DIV2 > DIV0) ? DIV2 : DIV0)
                                      : ((DIV1 > DIV0) ? DIV1 : DIV0),
  localparam int CW = (DMAX > 2) ? $clog2(DMAX) : 1
) (
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       clr_i,
  input  logic       run_i,
  input  logic [1:0] sel_i,
  input  logic       rc_tick_i,
  output logic       tick_o
);

  logic [CW-1:0] cnt_q;
  logic [CW-1:0] lim;
  logic          rc_mode;

  assign rc_mode = (sel_i == SEL_RC);

  always_comb begin
    unique case (sel_i)
      2'd0:    lim = CW'(DIV0 - 1);
      2'd1:    lim = CW'(DIV1 - 1);
      default: lim = CW'(DIV2 - 1);
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                  cnt_q <= '0;
    else if (clr_i)               cnt_q <= '0;
    else if (run_i && !rc_mode)   cnt_q <= (cnt_q == lim) ? '0 : cnt_q + 1'b1;
  end

  assign tick_o = run_i && (rc_mode ? rc_tick_i : (cnt_q == lim));

  // divided clock never yields back-to-back ticks
  assert_div_spacing_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (tick_o && !rc_mode) |=> !tick_o);

endmodule

// File: rtl/adc_seq_fsm.sv
module adc_seq_fsm
  import adc_seq_pkg::*;
#(
  parameter int CONV_TICKS  = 11,
  parameter int RECOV_TICKS = 2,
  localparam int TW = $clog2(CONV_TICKS)
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          q4_i,
  input  logic          go_set_i,
  input  logic          go_clr_i,
  input  logic          irq_clr_i,
  input  logic [1:0]    clk_sel_i,
  input  logic          tick_i,
  output seq_state_e    state_o,
  output logic [1:0]    sel_o,
  output logic          start_o,
  output logic          conv_tick_o,
  output logic [TW-1:0] tidx_o,
  output logic          done_o,
  output logic          go_o,
  output logic          irq_o,
  output logic          sample_o
);

  seq_state_e    state_q, state_d;
  logic [TW-1:0] tcnt_q;
  logic [1:0]    sel_q;
  logic          go_q, irq_q;
  logic          start, abort, done, recov_end;

  assign start     = (state_q == ST_IDLE) && go_q && q4_i && !go_clr_i;
  assign abort     = go_clr_i && ((state_q == ST_RCWAIT) || (state_q == ST_CONV));
  assign done      = (state_q == ST_CONV) && tick_i && !go_clr_i &&
                     (tcnt_q == TW'(CONV_TICKS - 1));
  assign recov_end = (state_q == ST_RECOV) && tick_i &&
                     (tcnt_q == TW'(RECOV_TICKS - 1));

  always_comb begin
    state_d = state_q;
    unique case (state_q)
      ST_IDLE:   if (start) state_d = (clk_sel_i == SEL_RC) ? ST_RCWAIT : ST_CONV;
      ST_RCWAIT: if (abort) state_d = ST_IDLE;
                 else if (q4_i) state_d = ST_CONV;
      ST_CONV:   if (abort) state_d = ST_IDLE;
                 else if (done) state_d = ST_RECOV;
      ST_RECOV:  if (recov_end) state_d = ST_IDLE;
      default:   state_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= ST_IDLE;
      tcnt_q  <= '0;
      sel_q   <= '0;
      go_q    <= 1'b0;
      irq_q   <= 1'b0;
    end else begin
      state_q <= state_d;
      if (start) sel_q <= clk_sel_i;
      if (start || done || abort)
        tcnt_q <= '0;
      else if (tick_i && (state_q == ST_CONV || state_q == ST_RECOV))
        tcnt_q <= tcnt_q + 1'b1;
      // cancel beats completion, completion beats a new set
      if (go_clr_i || done) go_q <= 1'b0;
      else if (go_set_i)    go_q <= 1'b1;
      if (done)             irq_q <= 1'b1;
      else if (irq_clr_i)   irq_q <= 1'b0;
    end
  end

  assign state_o     = state_q;
  assign sel_o       = sel_q;
  assign start_o     = start;
  assign conv_tick_o = tick_i && (state_q == ST_CONV);
  assign tidx_o      = tcnt_q;
  assign done_o      = done;
  assign go_o        = go_q;
  assign irq_o       = irq_q;
  assign sample_o    = !((state_q == ST_CONV) || (state_q == ST_RCWAIT));

  assert_start_on_q4_R1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(sample_o) |-> ($past(q4_i) && $past(go_q)));

  assert_go_irq_same_edge_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ($fell(go_q) && !$past(go_clr_i)) |-> irq_q);

  assert_no_restart_in_recov_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_q == ST_RECOV) |=> (state_q == ST_RECOV || state_q == ST_IDLE));

  assert_abort_clean_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $past(go_clr_i) |-> (!go_q && state_q != ST_CONV && state_q != ST_RCWAIT));

endmodule

// File: rtl/adc_seq_sar.sv
module adc_seq_sar #(
  parameter int RES_W = 8,
  parameter int TW    = 4
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             start_i,
  input  logic             tick_i,
  input  logic [TW-1:0]    tidx_i,
  input  logic             cmp_i,
  input  logic             load_i,
  output logic [RES_W-1:0] trial_o,
  output logic [RES_W-1:0] result_o
);

  localparam logic [RES_W-1:0] TOP = {1'b1, {(RES_W-1){1'b0}}};

  logic [RES_W-1:0] sar_q, mask_q, res_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      sar_q  <= '0;
      mask_q <= '0;
    end else if (start_i) begin
      sar_q  <= '0;
      mask_q <= '0;
    end else if (tick_i) begin
      if (tidx_i == '0) begin
        sar_q  <= TOP;
        mask_q <= TOP;
      end else if (tidx_i <= TW'(RES_W)) begin
        // keep or drop the bit under test, then raise the next lower one
        sar_q  <= (cmp_i ? sar_q : (sar_q & ~mask_q)) | (mask_q >> 1);
        mask_q <= mask_q >> 1;
      end
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)     res_q <= '0;
    else if (load_i) res_q <= sar_q;
  end

  assign trial_o  = sar_q;
  assign result_o = res_q;

  assert_single_trial_bit_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $onehot0(mask_q));

endmodule

// File: rtl/adc_sar_seq.sv
module adc_sar_seq
  import adc_seq_pkg::*;
#(
  parameter int RES_W       = 8,
  parameter int CONV_TICKS  = 11,
  parameter int RECOV_TICKS = 2,
  parameter int DIV0        = 2,
  parameter int DIV1        = 8,
  parameter int DIV2        = 32
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             q4_i,
  input  logic             go_set_i,
  input  logic             go_clr_i,
  input  logic             irq_clr_i,
  input  logic [1:0]       clk_sel_i,
  input  logic             rc_tick_i,
  input  logic             cmp_i,
  output logic [RES_W-1:0] trial_o,
  output logic             sample_o,
  output logic             go_o,
  output logic             irq_o,
  output logic [RES_W-1:0] result_o
);

  localparam int TW = $clog2(CONV_TICKS);

  seq_state_e    state;
  logic [1:0]    sel;
  logic          start, tick, conv_tick, done, run;
  logic [TW-1:0] tidx;

  assign run = (state == ST_CONV) || (state == ST_RECOV);

  adc_seq_clkgen #(
    .DIV0(DIV0), .DIV1(DIV1), .DIV2(DIV2)
  ) u_clkgen (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .clr_i     (start),
    .run_i     (run),
    .sel_i     (sel),
    .rc_tick_i (rc_tick_i),
    .tick_o    (tick)
  );

  adc_seq_fsm #(
    .CONV_TICKS(CONV_TICKS), .RECOV_TICKS(RECOV_TICKS)
  ) u_fsm (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .q4_i        (q4_i),
    .go_set_i    (go_set_i),
    .go_clr_i    (go_clr_i),
    .irq_clr_i   (irq_clr_i),
    .clk_sel_i   (clk_sel_i),
    .tick_i      (tick),
    .state_o     (state),
    .sel_o       (sel),
    .start_o     (start),
    .conv_tick_o (conv_tick),
    .tidx_o      (tidx),
    .done_o      (done),
    .go_o        (go_o),
    .irq_o       (irq_o),
    .sample_o    (sample_o)
  );

  adc_seq_sar #(
    .RES_W(RES_W), .TW(TW)
  ) u_sar (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .start_i  (start),
    .tick_i   (conv_tick),
    .tidx_i   (tidx),
    .cmp_i    (cmp_i),
    .load_i   (done),
    .trial_o  (trial_o),
    .result_o (result_o)
  );

  assert_result_only_at_done_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !$stable(result_o) |-> $fell(go_o));

endmodule

// File: tb/adc_sar_seq_tb.sv
module adc_sar_seq_tb;

  logic       clk = 1'b0;
  logic       rst_ni = 1'b0;
  logic       q4 = 1'b0, go_set = 1'b0, go_clr = 1'b0, irq_clr = 1'b0;
  logic [1:0] clk_sel = 2'd0;
  logic       rc_tick = 1'b0;
  logic       cmp;
  logic [7:0] trial, result, vin = 8'h00;
  logic       sample, go, irq;
  int         cyc = 0;
  int         checks = 0, errors = 0;

  always #2 clk = ~clk;
  always @(posedge clk) cyc <= cyc + 1;

  assign cmp = (vin >= trial);

  adc_sar_seq u_dut (
    .clk_i(clk), .rst_ni(rst_ni), .q4_i(q4), .go_set_i(go_set), .go_clr_i(go_clr),
    .irq_clr_i(irq_clr), .clk_sel_i(clk_sel), .rc_tick_i(rc_tick), .cmp_i(cmp),
    .trial_o(trial), .sample_o(sample), .go_o(go), .irq_o(irq), .result_o(result)
  );

  // {sel, code}
  localparam logic [9:0] VEC [8] = '{10'h000, 10'h0FF, 10'h1A5, 10'h101,
                                     10'h27F, 10'h380, 10'h33C, 10'h2C3};

  initial forever begin
    @(negedge clk);
    q4      = ((cyc % 4) == 3);
    rc_tick = ((cyc % 7) == 0);
  end

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  function automatic int div_of(input int sel);
    return (sel == 0) ? 2 : (sel == 1) ? 8 : 32;
  endfunction

  function automatic int q4_edge(input int lo);
    for (int e = lo; e < lo + 8; e++) if (((e - 1) % 4) == 3) return e;
    return -1;
  endfunction

  function automatic int rc_done(input int t0);
    int n = 0;
    for (int e = t0 + 5; e < t0 + 200; e++) begin
      if (((e - 1) % 7) == 0) n++;
      if (n == 11) return e;
    end
    return -1;
  endfunction

  task automatic run_conv(input int sel, input logic [7:0] code, input int min_idle,
                          output int tc);
    logic [7:0] old;
    int gw, t0, exp_st, exp_tc, n;
    bit held;
    old = result;
    @(negedge clk);
    clk_sel = 2'(sel); vin = code; go_set = 1'b1; irq_clr = 1'b1; gw = cyc;
    @(negedge clk);
    go_set = 1'b0; irq_clr = 1'b0;
    chk(irq == 1'b0, "R6 irq cleared", int'(irq), 0);
    exp_st = q4_edge(((gw + 2) > (min_idle + 1)) ? gw + 2 : min_idle + 1);
    n = 0;
    while (sample === 1'b1 && n < 500) begin @(negedge clk); n++; end
    t0 = cyc;
    chk(t0 == exp_st, (min_idle > 0) ? "R7 start after recovery" : "R1 start edge",
        t0, exp_st);
    held = 1'b1; n = 0;
    while (irq !== 1'b1 && n < 2000) begin
      if (result !== old || go !== 1'b1 || sample !== 1'b0) held = 1'b0;
      @(negedge clk); n++;
    end
    tc = cyc;
    chk(held, "R5 old result held", int'(result), int'(old));
    exp_tc = (sel == 3) ? rc_done(t0) : t0 + 11 * div_of(sel);
    chk(tc == exp_tc, (sel == 3) ? "R3 rc latency" : "R2 osc latency", tc - t0, exp_tc - t0);
    chk(result == code, "R4 final code", int'(result), int'(code));
    chk(go == 1'b0 && irq == 1'b1, "R6 go/irq at completion", int'({go, irq}), 1);
  endtask

  initial begin
    int tc, tc2;
    logic [7:0] old;
    bit clean;
    repeat (3) @(negedge clk);
    rst_ni = 1'b1;
    @(negedge clk);
    chk(result == 8'h00 && trial == 8'h00, "R5 reset result", int'(result), 0);
    chk(go == 1'b0 && irq == 1'b0, "R6 reset flags", int'({go, irq}), 0);
    chk(sample == 1'b1, "R1 reset sampling", int'(sample), 1);

    foreach (VEC[i]) begin
      run_conv(int'(VEC[i][9:8]), VEC[i][7:0], 0, tc);
      repeat (70) @(negedge clk);
      chk(irq == 1'b1, "R6 irq sticky", int'(irq), 1);
    end

    // R7: start written right after completion waits out recovery
    run_conv(1, 8'h33, 0, tc);
    run_conv(1, 8'hC4, tc + 16, tc2);
    repeat (70) @(negedge clk);

    // R8: cancel mid-conversion
    old = result;
    @(negedge clk);
    clk_sel = 2'd1; vin = 8'h5A; go_set = 1'b1; irq_clr = 1'b1;
    @(negedge clk);
    go_set = 1'b0; irq_clr = 1'b0;
    while (sample === 1'b1) @(negedge clk);
    repeat (20) @(negedge clk);
    go_clr = 1'b1;
    @(negedge clk);
    go_clr = 1'b0;
    chk(go == 1'b0 && sample == 1'b1, "R8 cancel returns to sample", int'({go, sample}), 1);
    clean = 1'b1;
    repeat (300) begin
      if (irq !== 1'b0 || result !== old || sample !== 1'b1) clean = 1'b0;
      @(negedge clk);
    end
    chk(clean, "R8 no irq, result kept", int'(result), int'(old));

    run_conv(0, 8'h96, 0, tc);

    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    checks++; errors++;
    $display("FAIL watchdog expired actual=%0d expected=%0d", cyc, 0);
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule